// File: doc/BRIEF.md
# Out-of-Order Reorder Buffer

This block is the in-flight instruction window of a small out-of-order core. It holds a ring of entries in program order. The decoder adds instructions at the tail. Ready instructions are handed to the execution units out of order. Results come back out of order. Instructions leave at the head strictly in program order, and each one that leaves either writes the register file or is discarded.

Each entry holds five things: the instruction word, a destination register, two source operands (each with a valid bit and a producer tag), a result, and a lifecycle state. The state is one of Empty, Waiting, Dispatched, Killed or Done. An entry's tag is its ring index, and that index is the name used on every port that refers to an entry.

A source operand that is not ready holds the tag of the entry that will produce it. Any writeback whose tag matches that operand fills it in. A mispredicted branch names its own entry, and every occupied entry younger than it is marked Killed. A Killed entry reaches the head later and is freed without a write.

The insert and issue ports are valid/ready streams:
- A transfer happens on a cycle where both valid and ready are high.
- The insert port refuses data while the buffer is full.
- An issue port keeps offering its current choice until it is taken.
- The writeback, branch and commit pins are plain strobes with no back-pressure.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty. `ins_ready` is 1, `ins_tag` is 0, and `alu_valid`, `mem_valid`, `rf_we` and `squash_ret` are all 0.
- R2: An insert is accepted when `ins_valid` and `ins_ready` are both high. The new entry takes tag `ins_tag`, and `ins_tag` then advances by one modulo DEPTH.
- R3: `ins_ready` is 0 exactly when DEPTH entries are occupied. While it is 0, `ins_valid` has no effect.
- R4: `alu_valid` is high exactly when some Waiting entry with `ins_mem`=0 has both operands valid. The port presents the oldest such entry, counted from the head, with its tag, instruction and operands. When the handshake completes the entry becomes Dispatched and is not offered again.
- R5: The memory issue port follows the rule of R4 for entries inserted with `ins_mem`=1.
- R6: A writeback (`awb_*` or `mwb_*`) to a Dispatched entry stores the data as the entry's result and makes the entry Done. A writeback to a Killed entry leaves it Killed.
- R7: Every writeback is also broadcast to the Waiting entries. Each Waiting entry whose invalid operand carries the writeback's tag takes the data and becomes valid. An insert in the same cycle as a writeback also takes that data for a not-ready operand whose tag matches.
- R8: `br_valid` with `br_tag` turns every occupied entry younger than `br_tag` into Killed, whatever state it was in. The named entry and all older entries are not changed.
- R9: When the head entry is Done, `rf_we` is high for one cycle with that entry's destination on `rf_waddr` and its result on `rf_wdata`. The entry then becomes Empty and the head advances.
- R10: When the head entry is Killed, `squash_ret` is high for one cycle and `rf_we` stays 0. The entry then becomes Empty and the head advances.
- R11: Entries retire in insertion order, at most one per cycle. `rf_we` and `squash_ret` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ins_valid | input | 1 | Insert request |
| ins_ready | output | 1 | Buffer can accept an insert |
| ins_tag | output | IDX_W | Tag the next accepted insert will receive |
| ins_instr | input | INSTR_W | Instruction word |
| ins_mem | input | 1 | 1 = memory-type, 0 = ALU-type |
| ins_dest | input | REG_W | Destination register |
| ins_a_val | input | DATA_W | Operand A value, used when `ins_a_rdy`=1 |
| ins_a_rdy | input | 1 | Operand A value is already known |
| ins_a_tag | input | IDX_W | Producer tag of operand A when not ready |
| ins_b_val | input | DATA_W | Operand B value |
| ins_b_rdy | input | 1 | Operand B value is already known |
| ins_b_tag | input | IDX_W | Producer tag of operand B |
| alu_valid | output | 1 | An ALU-type entry is offered |
| alu_ready | input | 1 | ALU unit takes the offer |
| alu_tag | output | IDX_W | Tag of the offered entry |
| alu_instr | output | INSTR_W | Its instruction |
| alu_a | output | DATA_W | Its operand A |
| alu_b | output | DATA_W | Its operand B |
| mem_valid | output | 1 | A memory-type entry is offered |
| mem_ready | input | 1 | Memory unit takes the offer |
| mem_tag | output | IDX_W | Tag of the offered entry |
| mem_instr | output | INSTR_W | Its instruction |
| mem_a | output | DATA_W | Its operand A |
| mem_b | output | DATA_W | Its operand B |
| awb_valid | input | 1 | ALU result strobe |
| awb_tag | input | IDX_W | Entry the ALU result belongs to |
| awb_data | input | DATA_W | ALU result |
| mwb_valid | input | 1 | Memory result strobe |
| mwb_tag | input | IDX_W | Entry the memory result belongs to |
| mwb_data | input | DATA_W | Memory result |
| br_valid | input | 1 | Mispredicted branch strobe |
| br_tag | input | IDX_W | Entry of the mispredicted branch |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | REG_W | Register-file write address |
| rf_wdata | output | DATA_W | Register-file write data |
| squash_ret | output | 1 | A killed head entry is freed this cycle |

## Verification
The assertions depend on the following input discipline:
- `br_tag` always names an occupied entry.
- A writeback only targets an entry that was issued and has not been written back yet.
- The two writebacks in one cycle carry different tags.
- An operand's producer tag names a live entry that is still Waiting or Dispatched.

The stimulus follows all of these rules. It draws producers and writeback targets only from the reference model's live entries. It never pairs a kill with an insert in the same cycle. It drops a pending writeback once its entry has retired. Under those limits the stimulus still runs the buffer into the full condition, overlaps kills with issue and writeback, and sends writebacks to entries that were issued and then killed.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [2:0] {
    ST_EMPTY = 3'd0,
    ST_WAIT  = 3'd1,
    ST_DISP  = 3'd2,
    ST_KILL  = 3'd3,
    ST_DONE  = 3'd4
  } rob_state_e;
endpackage

// File: rtl/rob_ring_ptr.sv
module rob_ring_ptr #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] tail_idx,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  // wrap bit in the MSB tells full from empty
  logic [CNT_W-1:0] head_q, tail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (push) tail_q <= tail_q + CNT_W'(1);
      if (pop)  head_q <= head_q + CNT_W'(1);
    end
  end

  assign head_idx = head_q[IDX_W-1:0];
  assign tail_idx = tail_q[IDX_W-1:0];
  assign count    = tail_q - head_q;
  assign full     = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/rob_oldest_pick.sv
module rob_oldest_pick #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] req,
  input  logic [IDX_W-1:0] head,
  output logic             found,
  output logic [IDX_W-1:0] sel
);
  logic [IDX_W-1:0] idx;

  // scan from youngest to oldest so the oldest request wins last
  always_comb begin
    found = 1'b0;
    sel   = head;
    idx   = head;
    for (int a = DEPTH - 1; a >= 0; a--) begin
      idx = head + IDX_W'(a);
      if (req[idx]) begin
        found = 1'b1;
        sel   = idx;
      end
    end
  end
endmodule

// File: rtl/rob_kill_mask.sv
module rob_kill_mask #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             br_valid,
  input  logic [IDX_W-1:0] br_idx,
  input  logic [IDX_W-1:0] head,
  input  logic [CNT_W-1:0] count,
  output logic [DEPTH-1:0] kill
);
  logic [IDX_W-1:0] age_br;
  assign age_br = br_idx - head;

  for (genvar i = 0; i < DEPTH; i++) begin : g_age
    logic [IDX_W-1:0] age_i;
    assign age_i   = IDX_W'(i) - head;
    assign kill[i] = br_valid && (age_i > age_br) && (CNT_W'(age_i) < count);
  end
endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int INSTR_W = 16,
  parameter int DATA_W  = 16,
  parameter int REG_W   = 5,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ins_valid,
  output logic               ins_ready,
  output logic [IDX_W-1:0]   ins_tag,
  input  logic [INSTR_W-1:0] ins_instr,
  input  logic               ins_mem,
  input  logic [REG_W-1:0]   ins_dest,
  input  logic [DATA_W-1:0]  ins_a_val,
  input  logic               ins_a_rdy,
  input  logic [IDX_W-1:0]   ins_a_tag,
  input  logic [DATA_W-1:0]  ins_b_val,
  input  logic               ins_b_rdy,
  input  logic [IDX_W-1:0]   ins_b_tag,
  output logic               alu_valid,
  input  logic               alu_ready,
  output logic [IDX_W-1:0]   alu_tag,
  output logic [INSTR_W-1:0] alu_instr,
  output logic [DATA_W-1:0]  alu_a,
  output logic [DATA_W-1:0]  alu_b,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic [IDX_W-1:0]   mem_tag,
  output logic [INSTR_W-1:0] mem_instr,
  output logic [DATA_W-1:0]  mem_a,
  output logic [DATA_W-1:0]  mem_b,
  input  logic               awb_valid,
  input  logic [IDX_W-1:0]   awb_tag,
  input  logic [DATA_W-1:0]  awb_data,
  input  logic               mwb_valid,
  input  logic [IDX_W-1:0]   mwb_tag,
  input  logic [DATA_W-1:0]  mwb_data,
  input  logic               br_valid,
  input  logic [IDX_W-1:0]   br_tag,
  output logic               rf_we,
  output logic [REG_W-1:0]   rf_waddr,
  output logic [DATA_W-1:0]  rf_wdata,
  output logic               squash_ret
);
  // ---------------- ring pointers ----------------
  logic [IDX_W-1:0] head_idx, tail_idx;
  logic [CNT_W-1:0] count;
  logic             full, ins_fire, retire;

  rob_ring_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .push(ins_fire), .pop(retire),
    .head_idx(head_idx), .tail_idx(tail_idx), .count(count), .full(full)
  );

  assign ins_ready = !full;
  assign ins_tag   = tail_idx;
  assign ins_fire  = ins_valid && !full;

  // ---------------- per-entry views ----------------
  rob_state_e       st_arr   [DEPTH];
  logic [INSTR_W-1:0] instr_arr [DEPTH];
  logic [REG_W-1:0]   dest_arr  [DEPTH];
  logic [DATA_W-1:0]  a_arr     [DEPTH];
  logic [DATA_W-1:0]  b_arr     [DEPTH];
  logic [DATA_W-1:0]  res_arr   [DEPTH];
  logic [DEPTH-1:0]   alu_req, mem_req, kill_vec;

  // ---------------- kill mask (R8) ----------------
  rob_kill_mask #(.DEPTH(DEPTH)) u_kill (
    .br_valid(br_valid), .br_idx(br_tag), .head(head_idx),
    .count(count), .kill(kill_vec)
  );

  // ---------------- issue selection (R4, R5) ----------------
  logic [IDX_W-1:0] alu_sel, mem_sel;
  logic             alu_found, mem_found, alu_fire, mem_fire;

  rob_oldest_pick #(.DEPTH(DEPTH)) u_pick_alu (
    .req(alu_req), .head(head_idx), .found(alu_found), .sel(alu_sel)
  );
  rob_oldest_pick #(.DEPTH(DEPTH)) u_pick_mem (
    .req(mem_req), .head(head_idx), .found(mem_found), .sel(mem_sel)
  );

  assign alu_valid = alu_found;
  assign alu_tag   = alu_sel;
  assign alu_instr = instr_arr[alu_sel];
  assign alu_a     = a_arr[alu_sel];
  assign alu_b     = b_arr[alu_sel];
  assign alu_fire  = alu_found && alu_ready;

  assign mem_valid = mem_found;
  assign mem_tag   = mem_sel;
  assign mem_instr = instr_arr[mem_sel];
  assign mem_a     = a_arr[mem_sel];
  assign mem_b     = b_arr[mem_sel];
  assign mem_fire  = mem_found && mem_ready;

  // ---------------- insert-time operand bypass (R7) ----------------
  logic [DATA_W-1:0] new_a, new_b;
  logic              new_av, new_bv;

  always_comb begin
    new_a  = ins_a_val;
    new_av = ins_a_rdy;
    if (!ins_a_rdy) begin
      if (awb_valid && awb_tag == ins_a_tag) begin
        new_a = awb_data; new_av = 1'b1;
      end else if (mwb_valid && mwb_tag == ins_a_tag) begin
        new_a = mwb_data; new_av = 1'b1;
      end
    end
    new_b  = ins_b_val;
    new_bv = ins_b_rdy;
    if (!ins_b_rdy) begin
      if (awb_valid && awb_tag == ins_b_tag) begin
        new_b = awb_data; new_bv = 1'b1;
      end else if (mwb_valid && mwb_tag == ins_b_tag) begin
        new_b = mwb_data; new_bv = 1'b1;
      end
    end
  end

  // ---------------- entries ----------------
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    localparam logic [IDX_W-1:0] ME = IDX_W'(i);

    rob_state_e         st_q;
    logic [INSTR_W-1:0] instr_q;
    logic               mem_q;
    logic [REG_W-1:0]   dest_q;
    logic [DATA_W-1:0]  a_q, b_q, res_q;
    logic               av_q, bv_q;
    logic [IDX_W-1:0]   at_q, bt_q;

    logic ins_here, iss_here, wba_here, wbm_here, ret_here;

    assign ins_here = ins_fire && (tail_idx == ME);
    assign iss_here = (alu_fire && alu_sel == ME) || (mem_fire && mem_sel == ME);
    assign wba_here = awb_valid && (awb_tag == ME);
    assign wbm_here = mwb_valid && (mwb_tag == ME);
    assign ret_here = retire && (head_idx == ME);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q    <= ST_EMPTY;
        instr_q <= '0;
        mem_q   <= 1'b0;
        dest_q  <= '0;
        a_q     <= '0;
        b_q     <= '0;
        res_q   <= '0;
        av_q    <= 1'b0;
        bv_q    <= 1'b0;
        at_q    <= '0;
        bt_q    <= '0;
      end else if (ins_here) begin
        st_q    <= ST_WAIT;
        instr_q <= ins_instr;
        mem_q   <= ins_mem;
        dest_q  <= ins_dest;
        a_q     <= new_a;
        av_q    <= new_av;
        at_q    <= ins_a_tag;
        b_q     <= new_b;
        bv_q    <= new_bv;
        bt_q    <= ins_b_tag;
      end else begin
        // lifecycle: retire beats kill beats normal progress
        if (ret_here)
          st_q <= ST_EMPTY;
        else if (kill_vec[i])
          st_q <= ST_KILL;
        else if (st_q == ST_WAIT && iss_here)
          st_q <= ST_DISP;
        else if (st_q == ST_DISP && (wba_here || wbm_here))
          st_q <= ST_DONE;

        if (st_q == ST_DISP && wba_here)
          res_q <= awb_data;
        else if (st_q == ST_DISP && wbm_here)
          res_q <= mwb_data;

        // wake-up broadcast
        if (st_q == ST_WAIT && !av_q) begin
          if (awb_valid && awb_tag == at_q) begin
            a_q <= awb_data; av_q <= 1'b1;
          end else if (mwb_valid && mwb_tag == at_q) begin
            a_q <= mwb_data; av_q <= 1'b1;
          end
        end
        if (st_q == ST_WAIT && !bv_q) begin
          if (awb_valid && awb_tag == bt_q) begin
            b_q <= awb_data; bv_q <= 1'b1;
          end else if (mwb_valid && mwb_tag == bt_q) begin
            b_q <= mwb_data; bv_q <= 1'b1;
          end
        end
      end
    end

    assign st_arr[i]    = st_q;
    assign instr_arr[i] = instr_q;
    assign dest_arr[i]  = dest_q;
    assign a_arr[i]     = a_q;
    assign b_arr[i]     = b_q;
    assign res_arr[i]   = res_q;
    assign alu_req[i]   = (st_q == ST_WAIT) && !mem_q && av_q && bv_q;
    assign mem_req[i]   = (st_q == ST_WAIT) &&  mem_q && av_q && bv_q;
  end

  // ---------------- in-order retirement (R9, R10, R11) ----------------
  rob_state_e head_st;
  assign head_st    = st_arr[head_idx];
  assign rf_we      = (head_st == ST_DONE);
  assign squash_ret = (head_st == ST_KILL);
  assign retire     = rf_we || squash_ret;
  assign rf_waddr   = dest_arr[head_idx];
  assign rf_wdata   = res_arr[head_idx];
endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ins_valid,
  input logic             ins_ready,
  input logic [IDX_W-1:0] ins_tag,
  input logic             alu_valid,
  input logic             alu_ready,
  input logic [IDX_W-1:0] alu_tag,
  input logic             mem_valid,
  input logic             mem_ready,
  input logic [IDX_W-1:0] mem_tag,
  input logic             br_valid,
  input logic             rf_we,
  input logic             squash_ret
);
  // occupancy seen only through the port handshakes
  logic [CNT_W-1:0] occ;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= '0;
    else occ <= occ + CNT_W'(ins_valid && ins_ready) - CNT_W'(rf_we || squash_ret);
  end

  a_r3_ready_vs_occupancy: assert property (@(posedge clk) disable iff (!rst_n)
    ins_ready == (occ != CNT_W'(DEPTH)));

  a_r2_tag_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_ready) |=> (ins_tag == $past(ins_tag) + IDX_W'(1)));

  a_r2_tag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(ins_valid && ins_ready) |=> $stable(ins_tag));

  a_r4_offer_persists: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_valid && !alu_ready && !br_valid) |=> alu_valid);

  a_r4_no_reissue: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_valid && alu_ready) |=> !(alu_valid && alu_tag == $past(alu_tag)));

  a_r5_offer_persists: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && !br_valid) |=> mem_valid);

  a_r5_no_reissue: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready) |=> !(mem_valid && mem_tag == $past(mem_tag)));

  a_r11_single_retire: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rf_we, squash_ret}) <= 1);

  a_r9_empty_no_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> !(rf_we || squash_ret));
endmodule

bind rob_core rob_core_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
  .ins_tag(ins_tag), .alu_valid(alu_valid), .alu_ready(alu_ready),
  .alu_tag(alu_tag), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_tag(mem_tag), .br_valid(br_valid), .rf_we(rf_we),
  .squash_ret(squash_ret)
);

// File: tb/rob_core_test.sv
module rob_core_test;
  localparam int DEPTH = 16;
  localparam int IW = 16;
  localparam int DW = 16;
  localparam int RW = 5;
  localparam int XW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5ns clk = ~clk;

  logic ins_valid, ins_ready, ins_mem, ins_a_rdy, ins_b_rdy;
  logic [XW-1:0] ins_tag, ins_a_tag, ins_b_tag;
  logic [IW-1:0] ins_instr;
  logic [RW-1:0] ins_dest;
  logic [DW-1:0] ins_a_val, ins_b_val;
  logic alu_valid, alu_ready, mem_valid, mem_ready;
  logic [XW-1:0] alu_tag, mem_tag;
  logic [IW-1:0] alu_instr, mem_instr;
  logic [DW-1:0] alu_a, alu_b, mem_a, mem_b;
  logic awb_valid, mwb_valid, br_valid;
  logic [XW-1:0] awb_tag, mwb_tag, br_tag;
  logic [DW-1:0] awb_data, mwb_data;
  logic rf_we, squash_ret;
  logic [RW-1:0] rf_waddr;
  logic [DW-1:0] rf_wdata;

  rob_core #(.DEPTH(DEPTH), .INSTR_W(IW), .DATA_W(DW), .REG_W(RW)) uut (.*);

  // ---------------- behavioural reference ----------------
  // states: 1 waiting, 2 dispatched, 3 killed, 4 done
  typedef struct {
    int tag; int st; bit mem; int instr; int dest;
    int a; bit av; int at; int b; bit bv; int bt;
    int res; bit iss; bit wbd;
  } ment_t;

  ment_t q[$];
  int next_tag = 0;
  int n_vec = 0;
  int n_bad = 0;
  int p_ins, p_ardy, p_mrdy, p_wb, p_kill;

  task automatic chk(string req, string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int oldest(bit want_mem);
    for (int k = 0; k < q.size(); k++)
      if (q[k].st == 1 && q[k].mem == want_mem && q[k].av && q[k].bv) return k;
    return -1;
  endfunction

  task automatic compare();
    int ak, mk;
    bit we, sq;
    chk("R3", "ins_ready", int'(ins_ready), int'(q.size() < DEPTH));
    chk("R2", "ins_tag", int'(ins_tag), next_tag);
    ak = oldest(1'b0);
    chk("R4", "alu_valid", int'(alu_valid), int'(ak >= 0));
    if (ak >= 0) begin
      chk("R4", "alu_tag", int'(alu_tag), q[ak].tag);
      chk("R4", "alu_instr", int'(alu_instr), q[ak].instr);
      chk("R4 R7", "alu_a", int'(alu_a), q[ak].a);
      chk("R4 R7", "alu_b", int'(alu_b), q[ak].b);
    end
    mk = oldest(1'b1);
    chk("R5", "mem_valid", int'(mem_valid), int'(mk >= 0));
    if (mk >= 0) begin
      chk("R5", "mem_tag", int'(mem_tag), q[mk].tag);
      chk("R5", "mem_instr", int'(mem_instr), q[mk].instr);
      chk("R5 R7", "mem_a", int'(mem_a), q[mk].a);
      chk("R5 R7", "mem_b", int'(mem_b), q[mk].b);
    end
    we = q.size() > 0 && q[0].st == 4;
    sq = q.size() > 0 && q[0].st == 3;
    chk("R9 R11", "rf_we", int'(rf_we), int'(we));
    chk("R8 R10", "squash_ret", int'(squash_ret), int'(sq));
    if (we) begin
      chk("R9", "rf_waddr", int'(rf_waddr), q[0].dest);
      chk("R6 R9", "rf_wdata", int'(rf_wdata), q[0].res);
    end
  endtask

  function automatic bit rnd(int pct);
    return int'($urandom_range(99)) < pct;
  endfunction

  task automatic drive_and_model();
    int ak, mk, kb, ret_st;
    int cand[$];
    int prods[$];
    bit fire_ins;
    ment_t e, n;
    alu_ready = rnd(p_ardy);
    mem_ready = rnd(p_mrdy);
    awb_valid = 0; mwb_valid = 0; br_valid = 0; ins_valid = 0;
    awb_tag = '0; mwb_tag = '0; br_tag = '0;
    awb_data = DW'($urandom); mwb_data = DW'($urandom);
    // writebacks only to issued, not yet written entries
    cand.delete();
    for (int k = 0; k < q.size(); k++) if (!q[k].mem && q[k].iss && !q[k].wbd) cand.push_back(k);
    if (cand.size() > 0 && rnd(p_wb)) begin
      awb_valid = 1; awb_tag = XW'(q[cand[$urandom_range(cand.size()-1)]].tag);
    end
    cand.delete();
    for (int k = 0; k < q.size(); k++) if (q[k].mem && q[k].iss && !q[k].wbd) cand.push_back(k);
    if (cand.size() > 0 && rnd(p_wb)) begin
      mwb_valid = 1; mwb_tag = XW'(q[cand[$urandom_range(cand.size()-1)]].tag);
    end
    kb = -1;
    if (q.size() > 0 && rnd(p_kill)) begin
      kb = int'($urandom_range(q.size()-1));
      br_valid = 1; br_tag = XW'(q[kb].tag);
    end
    if (kb < 0 && rnd(p_ins)) begin
      ins_valid = 1;
      ins_instr = IW'($urandom); ins_mem = rnd(40); ins_dest = RW'($urandom);
      ins_a_val = DW'($urandom); ins_b_val = DW'($urandom);
      ins_a_rdy = 1; ins_b_rdy = 1; ins_a_tag = '0; ins_b_tag = '0;
      prods.delete();
      for (int k = 0; k < q.size(); k++) if (q[k].st == 1 || q[k].st == 2) prods.push_back(q[k].tag);
      if (prods.size() > 0 && rnd(50)) begin
        ins_a_rdy = 0; ins_a_tag = XW'(prods[$urandom_range(prods.size()-1)]);
      end
      if (prods.size() > 0 && rnd(40)) begin
        ins_b_rdy = 0; ins_b_tag = XW'(prods[$urandom_range(prods.size()-1)]);
      end
    end
    // ---- next state of the reference ----
    ak = oldest(1'b0);
    mk = oldest(1'b1);
    ret_st = (q.size() > 0) ? q[0].st : 0;
    fire_ins = ins_valid && q.size() < DEPTH;
    for (int k = 0; k < q.size(); k++) begin
      int pst;
      e = q[k];
      pst = e.st;
      if (k == ak && alu_ready) begin e.st = 2; e.iss = 1; end
      if (k == mk && mem_ready) begin e.st = 2; e.iss = 1; end
      if (awb_valid && int'(awb_tag) == e.tag) begin
        e.wbd = 1;
        if (pst == 2) begin e.st = 4; e.res = int'(awb_data); end
      end
      if (mwb_valid && int'(mwb_tag) == e.tag) begin
        e.wbd = 1;
        if (pst == 2) begin e.st = 4; e.res = int'(mwb_data); end
      end
      if (pst == 1) begin
        if (!e.av && awb_valid && e.at == int'(awb_tag)) begin e.a = int'(awb_data); e.av = 1; end
        else if (!e.av && mwb_valid && e.at == int'(mwb_tag)) begin e.a = int'(mwb_data); e.av = 1; end
        if (!e.bv && awb_valid && e.bt == int'(awb_tag)) begin e.b = int'(awb_data); e.bv = 1; end
        else if (!e.bv && mwb_valid && e.bt == int'(mwb_tag)) begin e.b = int'(mwb_data); e.bv = 1; end
      end
      if (br_valid && k > kb) e.st = 3;
      q[k] = e;
    end
    if (ret_st == 3 || ret_st == 4) void'(q.pop_front());
    if (fire_ins) begin
      n.tag = next_tag; n.st = 1; n.mem = ins_mem; n.instr = int'(ins_instr);
      n.dest = int'(ins_dest); n.res = 0; n.iss = 0; n.wbd = 0;
      n.at = int'(ins_a_tag); n.bt = int'(ins_b_tag);
      n.a = int'(ins_a_val); n.av = ins_a_rdy;
      if (!ins_a_rdy && awb_valid && ins_a_tag == awb_tag) begin n.a = int'(awb_data); n.av = 1; end
      else if (!ins_a_rdy && mwb_valid && ins_a_tag == mwb_tag) begin n.a = int'(mwb_data); n.av = 1; end
      n.b = int'(ins_b_val); n.bv = ins_b_rdy;
      if (!ins_b_rdy && awb_valid && ins_b_tag == awb_tag) begin n.b = int'(awb_data); n.bv = 1; end
      else if (!ins_b_rdy && mwb_valid && ins_b_tag == mwb_tag) begin n.b = int'(mwb_data); n.bv = 1; end
      q.push_back(n);
      next_tag = (next_tag + 1) % DEPTH;
    end
  endtask

  task automatic run(int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      compare();
      drive_and_model();
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    #2ms;
    n_bad++;
    $display("FAIL watchdog run did not finish");
    summary();
    $finish;
  end

  initial begin
    ins_valid = 0; ins_instr = '0; ins_mem = 0; ins_dest = '0;
    ins_a_val = '0; ins_a_rdy = 1; ins_a_tag = '0;
    ins_b_val = '0; ins_b_rdy = 1; ins_b_tag = '0;
    alu_ready = 0; mem_ready = 0;
    awb_valid = 0; awb_tag = '0; awb_data = '0;
    mwb_valid = 0; mwb_tag = '0; mwb_data = '0;
    br_valid = 0; br_tag = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "ins_ready after reset", int'(ins_ready), 1);
    chk("R1", "ins_tag after reset", int'(ins_tag), 0);
    chk("R1", "alu_valid after reset", int'(alu_valid), 0);
    chk("R1", "mem_valid after reset", int'(mem_valid), 0);
    chk("R1", "rf_we after reset", int'(rf_we), 0);
    chk("R1", "squash_ret after reset", int'(squash_ret), 0);
    // fill to full with nothing leaving (R3 refusal while full)
    p_ins = 100; p_ardy = 0; p_mrdy = 0; p_wb = 0; p_kill = 0;
    run(30);
    chk("R3", "ins_ready when full", int'(ins_ready), 0);
    // mixed traffic, moderate kills
    p_ins = 70; p_ardy = 60; p_mrdy = 50; p_wb = 60; p_kill = 3;
    run(3000);
    // heavy kills with writebacks racing them (R6 R8 R10)
    p_ins = 80; p_ardy = 80; p_mrdy = 80; p_wb = 50; p_kill = 15;
    run(1500);
    // slow issue, back-pressure on both issue ports
    p_ins = 90; p_ardy = 20; p_mrdy = 20; p_wb = 80; p_kill = 2;
    run(1500);
    // drain
    p_ins = 0; p_ardy = 100; p_mrdy = 100; p_wb = 100; p_kill = 0;
    for (int c = 0; c < 400 && q.size() > 0; c++) run(1);
    run(2);
    chk("R9 R11", "buffer drained", int'(ins_ready && !alu_valid && !mem_valid), 1);
    summary();
    $finish;
  end
endmodule